// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

The engine moves a block of words between a device data port and memory with no processor involvement once the transfer has started. Software programs three registers: a control/status word, a start memory address and a word count. Writing the control word while a nonzero count is loaded starts the block. The engine then requests the memory port, moves one word in each granted cycle, steps the address up and the count down, and sets a completion flag when the count runs out. If interrupts are enabled, that flag also raises an interrupt.

Two pacing modes are available. In cycle-steal mode the request drops for one cycle after every granted word, so other bus users can take cycles between the engine's words. In burst mode the request stays high until the whole block has moved. The engine requests only while the device side can take part: it waits for the device to offer a word when writing memory, and for the device to have space when reading memory.

Top module: `dma_channel`

## Requirements
- R1: After reset, all three registers read zero, mem_req_o is low and irq_o is low.
- R2: Register select 1 holds the start address and select 2 holds the word count, and both read back what was written. Select 0 reads the status word: IRQ at bit 31, Done at bit 30, busy at bit 29, burst mode at bit 2, interrupt enable at bit 1 and direction at bit 0. The other bits read zero.
- R3: A write to select 0 while idle loads bits 2..0. It starts a transfer only if the count is nonzero. With a zero count, mem_req_o stays low and Done is unchanged.
- R4: With direction 0 (device to memory), word k taken from dev_data_i is written to address start+k, with mem_we_o high.
- R5: With direction 1 (memory to device), the word read at address start+k is the k-th word pushed on dev_wdata_o, with mem_we_o low.
- R6: Each granted word adds one to the address register and subtracts one from the count register. While the block runs, the count register reads back the remaining count. At the end the address reads start+N and the count reads 0.
- R7: In cycle-steal mode (bit 2 = 0), mem_req_o is low in the cycle after every granted word.
- R8: In burst mode (bit 2 = 1), mem_req_o stays high from word to word. With a grant every cycle, an N-word block takes N back-to-back granted cycles.
- R9: Done is set when the last word moves and is cleared when a new transfer starts.
- R10: At completion, IRQ and irq_o are set only if interrupt enable was 1. A read of select 0 clears IRQ, and Done stays set.
- R11: While a transfer is busy, writes to any register are ignored.
- R12: mem_req_o is high only when the device side is ready (dev_avail_i for direction 0, dev_space_i for direction 1). Stalls on the grant or on the device lose no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 2 | Register select: 0 control/status, 1 address, 2 count |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (a read of select 0 clears IRQ) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_sel_i |
| mem_req_o | output | 1 | Memory access request |
| mem_gnt_i | input | 1 | Grant; the word moves in a cycle where request and grant are both high |
| mem_we_o | output | 1 | 1 = write to memory, 0 = read from memory |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 32 | Data written to memory |
| mem_rdata_i | input | 32 | Data read from memory, valid in the granted cycle |
| dev_avail_i | input | 1 | Device has a word on dev_data_i |
| dev_data_i | input | 32 | Word from the device |
| dev_pop_o | output | 1 | Device word consumed this cycle |
| dev_space_i | input | 1 | Device can accept a word |
| dev_push_o | output | 1 | Word on dev_wdata_o delivered this cycle |
| dev_wdata_o | output | 32 | Word to the device |
| irq_o | output | 1 | Completion interrupt |

## Verification
The assertions assume that mem_gnt_i is high only in cycles where mem_req_o is high. They also assume that mem_rdata_i is valid in the granted cycle. The bench builds its grant as its own enable ANDed with mem_req_o, and its memory model answers reads combinationally from mem_addr_o. It writes registers only between transfers, except in the deliberate test of ignored writes. It drives the device readiness and grant-enable inputs at falling edges, using either a fixed pattern or a shift-register pattern.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_ADDR  = 2'd1,
    SEL_COUNT = 2'd2
  } reg_sel_e;

  localparam int unsigned BIT_IRQ   = 31;
  localparam int unsigned BIT_DONE  = 30;
  localparam int unsigned BIT_BUSY  = 29;
  localparam int unsigned BIT_BURST = 2;
  localparam int unsigned BIT_IE    = 1;
  localparam int unsigned BIT_DIR   = 0;

  typedef struct packed {
    logic burst;
    logic ie;
    logic dir;
  } cfg_t;
endpackage

// File: rtl/dma_csr.sv
module dma_csr
  import dma_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_wr_i,
  input  logic          status_rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          busy_i,
  input  logic          fin_i,
  input  logic          cnt_nz_i,
  output logic          start_o,
  output cfg_t          cfg_o,
  output logic          done_o,
  output logic          irq_o
);
  logic cfg_we;

  assign cfg_we  = ctrl_wr_i && !busy_i;
  assign start_o = cfg_we && cnt_nz_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= '0;
      done_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (cfg_we) begin
        cfg_o.burst <= wdata_i[BIT_BURST];
        cfg_o.ie    <= wdata_i[BIT_IE];
        cfg_o.dir   <= wdata_i[BIT_DIR];
      end
      if (start_o)    done_o <= 1'b0;
      else if (fin_i) done_o <= 1'b1;
      // completion wins over a same-cycle status read
      if (fin_i && cfg_o.ie)             irq_o <= 1'b1;
      else if (start_o || status_rd_i)   irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_track.sv
module dma_track #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_wr_i,
  input  logic          cnt_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          busy_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] count_o,
  output logic          last_o,
  output logic          cnt_nz_o
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  assign last_o   = (count_o == CNT_ONE);
  assign cnt_nz_o = (count_o != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      count_o <= '0;
    end else if (busy_i) begin
      if (step_i) begin
        addr_o  <= addr_o + AW'(1);
        count_o <= count_o - CNT_ONE;
      end
    end else begin
      if (addr_wr_i) addr_o  <= wdata_i[AW-1:0];
      if (cnt_wr_i)  count_o <= wdata_i[CW-1:0];
    end
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic burst_i,
  input  logic dir_i,
  input  logic dev_avail_i,
  input  logic dev_space_i,
  input  logic gnt_i,
  input  logic last_i,
  output logic busy_o,
  output logic req_o,
  output logic step_o,
  output logic fin_o
);
  logic gap_q;
  logic dev_ok;

  assign dev_ok = dir_i ? dev_space_i : dev_avail_i;
  assign req_o  = busy_o && !gap_q && dev_ok;
  assign step_o = req_o && gnt_i;
  assign fin_o  = step_o && last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      gap_q  <= 1'b0;
    end else begin
      if (start_i)    busy_o <= 1'b1;
      else if (fin_o) busy_o <= 1'b0;
      // steal mode: give the bus away for one cycle after each word
      gap_q <= step_o && !burst_i && !last_i;
    end
  end
endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    reg_sel_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          mem_req_o,
  input  logic          mem_gnt_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          dev_avail_i,
  input  logic [DW-1:0] dev_data_i,
  output logic          dev_pop_o,
  input  logic          dev_space_i,
  output logic          dev_push_o,
  output logic [DW-1:0] dev_wdata_o,
  output logic          irq_o
);
  logic          ctrl_wr, addr_wr, cnt_wr, status_rd;
  logic          busy, step, fin, last, cnt_nz, start, done;
  cfg_t          cfg;
  logic [AW-1:0] addr;
  logic [CW-1:0] count;

  assign ctrl_wr   = reg_wr_i && (reg_sel_i == SEL_CTRL);
  assign addr_wr   = reg_wr_i && (reg_sel_i == SEL_ADDR);
  assign cnt_wr    = reg_wr_i && (reg_sel_i == SEL_COUNT);
  assign status_rd = reg_rd_i && (reg_sel_i == SEL_CTRL);

  dma_csr #(.DW(DW)) csr_i (
    .clk_i, .rst_ni,
    .ctrl_wr_i(ctrl_wr), .status_rd_i(status_rd), .wdata_i(reg_wdata_i),
    .busy_i(busy), .fin_i(fin), .cnt_nz_i(cnt_nz),
    .start_o(start), .cfg_o(cfg), .done_o(done), .irq_o(irq_o)
  );

  dma_track #(.DW(DW), .AW(AW), .CW(CW)) track_i (
    .clk_i, .rst_ni,
    .addr_wr_i(addr_wr), .cnt_wr_i(cnt_wr), .wdata_i(reg_wdata_i),
    .busy_i(busy), .step_i(step),
    .addr_o(addr), .count_o(count), .last_o(last), .cnt_nz_o(cnt_nz)
  );

  dma_seq seq_i (
    .clk_i, .rst_ni,
    .start_i(start), .burst_i(cfg.burst), .dir_i(cfg.dir),
    .dev_avail_i, .dev_space_i, .gnt_i(mem_gnt_i), .last_i(last),
    .busy_o(busy), .req_o(mem_req_o), .step_o(step), .fin_o(fin)
  );

  assign mem_we_o    = mem_req_o && !cfg.dir;
  assign mem_addr_o  = addr;
  assign mem_wdata_o = dev_data_i;
  assign dev_pop_o   = step && !cfg.dir;
  assign dev_push_o  = step && cfg.dir;
  assign dev_wdata_o = mem_rdata_i;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_sel_i)
      SEL_CTRL: begin
        reg_rdata_o[BIT_IRQ]   = irq_o;
        reg_rdata_o[BIT_DONE]  = done;
        reg_rdata_o[BIT_BUSY]  = busy;
        reg_rdata_o[BIT_BURST] = cfg.burst;
        reg_rdata_o[BIT_IE]    = cfg.ie;
        reg_rdata_o[BIT_DIR]   = cfg.dir;
      end
      SEL_ADDR:  reg_rdata_o = DW'(addr);
      SEL_COUNT: reg_rdata_o = DW'(count);
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk
  import dma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic          mem_gnt_i,
  input logic          mem_we_o,
  input logic          dev_avail_i,
  input logic          dev_space_i,
  input logic          irq_o,
  input logic          busy,
  input logic          done,
  input cfg_t          cfg,
  input logic [AW-1:0] addr,
  input logic [CW-1:0] count
);
  logic dev_ok;
  assign dev_ok = cfg.dir ? dev_space_i : dev_avail_i;

  assert_gnt_qualified_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_gnt_i |-> mem_req_o);

  assert_req_when_ready_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (busy && dev_ok));

  assert_we_dir_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_we_o == !cfg.dir));

  assert_addr_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i) |=> (addr == $past(addr) + AW'(1)));

  assert_count_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i) |=> (count == $past(count) - CW'(1)));

  assert_steal_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg.burst && mem_req_o && mem_gnt_i) |=> !mem_req_o);

  assert_burst_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.burst && mem_req_o && mem_gnt_i && count > CW'(1)) |=> (mem_req_o || !dev_ok));

  assert_done_on_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done) |-> (!busy && count == '0));

  assert_irq_qualified_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (done && cfg.ie));
endmodule

bind dma_channel dma_channel_chk #(.AW(AW), .CW(CW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_gnt_i(mem_gnt_i),
  .mem_we_o(mem_we_o), .dev_avail_i(dev_avail_i), .dev_space_i(dev_space_i),
  .irq_o(irq_o), .busy(busy), .done(done), .cfg(cfg), .addr(addr), .count(count)
);

// File: tb/dma_channel_tb_top.sv
`timescale 1ns/1ps
module dma_channel_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  reg_sel_i = '0;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        mem_req_o, mem_gnt_i, mem_we_o;
  logic [15:0] mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i;
  logic        dev_avail_i, dev_space_i, dev_pop_o, dev_push_o, irq_o;
  logic [31:0] dev_data_i, dev_wdata_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic        gnt_en = 1'b1, avail_en = 1'b1, space_en = 1'b1, use_lfsr = 1'b0;
  logic [7:0]  lfsr = 8'hA5;
  logic [31:0] mem [0:63];
  logic [31:0] sink [0:63];
  int          sink_n = 0, src_idx = 0, b2b = 0;
  logic [31:0] src_base = 32'h0;
  logic        prev_step = 1'b0;

  always #10 clk_i = ~clk_i;

  dma_channel dut_i (.*);

  assign mem_gnt_i   = mem_req_o & (use_lfsr ? lfsr[0] : gnt_en);
  assign dev_avail_i = use_lfsr ? lfsr[3] : avail_en;
  assign dev_space_i = space_en;
  assign dev_data_i  = src_base + 32'(src_idx);
  assign mem_rdata_i = mem[mem_addr_o[5:0]];

  always @(negedge clk_i) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  always @(posedge clk_i) begin
    if (mem_req_o && mem_gnt_i && mem_we_o) mem[mem_addr_o[5:0]] <= mem_wdata_o;
    if (dev_push_o) begin sink[sink_n[5:0]] <= dev_wdata_o; sink_n <= sink_n + 1; end
    if (dev_pop_o) src_idx <= src_idx + 1;
    prev_step <= mem_req_o && mem_gnt_i;
    if (mem_req_o && mem_gnt_i && prev_step) b2b <= b2b + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk_i); reg_sel_i = sel; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk_i); reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk_i); reg_sel_i = sel; reg_rd_i = 1'b1;
    #1 d = reg_rdata_o;
    @(negedge clk_i); reg_rd_i = 1'b0;
  endtask

  task automatic wait_done();
    logic [31:0] c;
    for (int i = 0; i < 2000; i++) begin
      rd(2'd2, c);
      if (c == 0) return;
    end
    check("R6 timeout", c, 32'h0);
  endtask

  task automatic clear_stats();
    @(negedge clk_i); b2b = 0; sink_n = 0; src_idx = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); check("R1 ctrl", d, 32'h0);
    rd(2'd1, d); check("R1 addr", d, 32'h0);
    rd(2'd2, d); check("R1 count", d, 32'h0);
    check("R1 req", {31'h0, mem_req_o}, 32'h0);
    check("R1 irq", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bit saw_req = 0;
    wr(2'd1, 32'h0000_1234); rd(2'd1, d); check("R2 addr readback", d, 32'h1234);
    wr(2'd2, 32'h0000_0005); rd(2'd2, d); check("R2 count readback", d, 32'h5);
    wr(2'd2, 32'h0);
    wr(2'd0, 32'hFFFF_FFFF);
    for (int i = 0; i < 6; i++) begin @(negedge clk_i); if (mem_req_o) saw_req = 1; end
    check("R3 no start on zero count", {31'h0, saw_req}, 32'h0);
    rd(2'd0, d); check("R2 R3 ctrl layout", d, 32'h0000_0007);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_d2m_steal();
    logic [31:0] d;
    clear_stats(); src_base = 32'hA000_0000; gnt_en = 1; avail_en = 1;
    wr(2'd1, 32'd8); wr(2'd2, 32'd6); wr(2'd0, 32'h2);
    wr(2'd1, 32'h30); wr(2'd0, 32'h0);  // ignored while busy
    rd(2'd2, d);
    check("R6 remaining count mid-block", {31'h0, (d > 0 && d < 6)}, 32'h1);
    wait_done();
    for (int k = 0; k < 6; k++) check("R4 memory word", mem[8 + k], 32'hA000_0000 + 32'(k));
    rd(2'd1, d); check("R6 R11 final addr", d, 32'd14);
    check("R7 no back-to-back grants", 32'(b2b), 32'h0);
    check("R10 irq_o set", {31'h0, irq_o}, 32'h1);
    rd(2'd0, d); check("R9 R10 R11 status", d, 32'hC000_0002);
    @(negedge clk_i);
    check("R10 irq cleared by read", {31'h0, irq_o}, 32'h0);
    rd(2'd0, d); check("R10 done stays", d, 32'h4000_0002);
  endtask

  task automatic t_m2d_burst();
    logic [31:0] d;
    for (int k = 0; k < 8; k++) mem[32 + k] = 32'h5A00_0000 ^ (32'(k) * 32'h0101_0101);
    clear_stats(); gnt_en = 1; space_en = 1;
    wr(2'd1, 32'd32); wr(2'd2, 32'd8); wr(2'd0, 32'h5);
    wait_done();
    check("R5 pushed words", 32'(sink_n), 32'd8);
    for (int k = 0; k < 8; k++)
      check("R5 device word", sink[k], 32'h5A00_0000 ^ (32'(k) * 32'h0101_0101));
    check("R8 back-to-back grants", 32'(b2b), 32'd7);
    rd(2'd2, d); check("R6 count zero", d, 32'h0);
    check("R10 no irq with IE=0", {31'h0, irq_o}, 32'h0);
    rd(2'd0, d); check("R10 status IE=0", d, 32'h4000_0005);
  endtask

  task automatic t_stall();
    logic [31:0] d;
    bit bad_req = 0;
    clear_stats(); src_base = 32'h0C00_0000; use_lfsr = 1;
    wr(2'd1, 32'd48); wr(2'd2, 32'd10); wr(2'd0, 32'h4);
    rd(2'd0, d); check("R9 done cleared on start", d & 32'h6000_0000, 32'h2000_0000);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk_i); #1;
      if (mem_req_o && !dev_avail_i) bad_req = 1;
    end
    check("R12 request only when device ready", {31'h0, bad_req}, 32'h0);
    wait_done();
    use_lfsr = 0;
    for (int k = 0; k < 10; k++) check("R12 stalled word", mem[48 + k], 32'h0C00_0000 + 32'(k));
    rd(2'd1, d); check("R6 final addr stall", d, 32'd58);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_regs();
    t_d2m_steal();
    t_m2d_burst();
    t_stall();
    repeat (4) @(negedge clk_i);
    summary();
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule